// File: doc/BRIEF.md
# Trigger Class and Cluster Decision Logic

This block makes the trigger decision at one level of a multi-level trigger. It evaluates a set of programmable trigger classes against the current trigger inputs. A class is a product term over a chosen group of inputs. It also needs its chosen pile-up protection results to be good, and the busy line it watches must be idle. The classes that fire are then merged by OR into detector cluster triggers. One class may feed several clusters, so clusters can overlap.

The same cycle also produces two interaction signals. Each is an arbitrary function of the four lowest trigger inputs, held as a 16-entry truth table. Configuration arrives on static, flattened vector ports and is expected to stay still while the block runs. At later decision levels, the busy inputs carry the delayed decision of the previous level instead of real detector busy. All outputs are registered once per bunch-crossing clock.

Top module: `tcl_level_core`

## Requirements
- R1: A class fires only when every input in its select mask (bit k*NIN+i of `cfg_in_sel` selects input i for class k) is at its required level. The required level is high unless the input is inverted.
- R2: A class whose select mask is all zero never fires, whatever the other inputs are.
- R3: Only classes 0 to NINV-1 (default 0 to 5) can invert inputs. Bit k*NIN+i of `cfg_in_inv` set means input i must be low for class k.
- R4: A class fires only when every protection flag picked by its mask (bit k*NPF+j of `cfg_pf_sel`) is high.
- R5: Each class holds a 3-bit busy index (`cfg_busy_sel` bits k*3+:3). Values 0 to 5 name the cluster busy line that blocks the class. Values 6 and 7 mean the class is never blocked by busy.
- R6: Cluster trigger c is the OR of all fired classes k whose map bit k*NCLUS+c of `cfg_clus_map` is set. A class may drive several clusters.
- R7: Interaction signal i equals bit n of `cfg_int_lut[i*16 +: 16]`, where n is the value of `trig_in[3:0]`.
- R8: The class, cluster and interaction outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R9: A synchronous active-low reset clears all outputs to zero on the next rising edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 24 | Trigger inputs of this level |
| pf_ok | input | 4 | Protection results, high = no pile-up |
| clus_busy | input | 6 | Per-cluster busy or previous-level veto |
| cfg_in_sel | input | 1200 | Per-class input select masks |
| cfg_in_inv | input | 144 | Inversion masks for classes 0 to 5 |
| cfg_pf_sel | input | 200 | Per-class protection select masks |
| cfg_busy_sel | input | 150 | Per-class busy index, 3 bits each |
| cfg_clus_map | input | 300 | Per-class cluster membership |
| cfg_int_lut | input | 32 | Two 16-entry interaction truth tables |
| class_fire | output | 50 | Registered class decisions |
| clus_trig | output | 6 | Registered cluster triggers |
| int_sig | output | 2 | Registered interaction signals |

## Verification
The checker assumes that the configuration ports do not change while reset is released. Its properties compare each class decision with the inputs of the previous cycle through the masks present now, so the masks must be the same in both cycles. The bench sets every configuration vector before it releases reset and never touches them again. Only the trigger, protection and busy inputs change, and they change on falling edges. The busy property also relies on index values above 5 reading as an idle line. The bench uses index 7 for that case.

// File: rtl/tcl_pkg.sv
// Package: shared sizing constants for the trigger class and cluster logic.
// Assumes: one decision level; all counts may be overridden per instance.
package tcl_pkg;
    localparam int TCL_NCLASS = 50;  // programmable classes
    localparam int TCL_NIN    = 24;  // trigger inputs
    localparam int TCL_NPF    = 4;   // protection flags
    localparam int TCL_NCLUS  = 6;   // detector clusters
    localparam int TCL_NINV   = 6;   // classes allowed to invert inputs
    localparam int TCL_NINT   = 2;   // interaction signals
    localparam int TCL_LUTSEL = 4;   // inputs feeding each interaction table
endpackage

// File: rtl/tcl_class_eval.sv
// Module: combinational evaluation of one trigger class.
// Assumes: inv is tied to zero by the parent for classes without inversion;
// busy index values beyond the last cluster select a zero pad bit.
module tcl_class_eval #(
    parameter int NIN   = 24,
    parameter int NPF   = 4,
    parameter int NCLUS = 6,
    parameter int BSW   = 3
) (
    input  logic [NIN-1:0]   trig,
    input  logic [NIN-1:0]   sel,
    input  logic [NIN-1:0]   inv,
    input  logic [NPF-1:0]   pf,
    input  logic [NPF-1:0]   pf_sel,
    input  logic [NCLUS-1:0] busy,
    input  logic [BSW-1:0]   busy_idx,
    output logic             fire
);
    localparam int BEXT = 2 ** BSW;

    logic [NIN-1:0]  level;
    logic [BEXT-1:0] busy_ext;
    logic            in_ok, any_sel, pf_good, vetoed;

    // Product term: apply polarity, mask unselected inputs, and gate by protection and busy.
    always_comb begin
        level    = trig ^ inv;
        in_ok    = &(level | ~sel);
        any_sel  = |sel;
        pf_good  = &(pf | ~pf_sel);
        busy_ext = '0;
        busy_ext[NCLUS-1:0] = busy;
        vetoed   = busy_ext[busy_idx];
        fire     = any_sel & in_ok & pf_good & ~vetoed;
    end
endmodule

// File: rtl/tcl_cluster_or.sv
// Module: merges class decisions into cluster triggers by OR.
// Assumes: map bit k*NCLUS+c attaches class k to cluster c; overlap allowed.
module tcl_cluster_or #(
    parameter int NCLASS = 50,
    parameter int NCLUS  = 6
) (
    input  logic [NCLASS-1:0]       fire,
    input  logic [NCLASS*NCLUS-1:0] map,
    output logic [NCLUS-1:0]        clus
);
    for (genvar c = 0; c < NCLUS; c++) begin : g_clus
        logic [NCLASS-1:0] member;
        // Gather the membership column of cluster c.
        always_comb begin
            for (int k = 0; k < NCLASS; k++) member[k] = map[k*NCLUS + c];
        end
        assign clus[c] = |(fire & member);
    end
endmodule

// File: rtl/tcl_int_lut.sv
// Module: one interaction signal as a truth table over a few inputs.
// Assumes: table bit n is the output when the select inputs read n.
module tcl_int_lut #(
    parameter int NSEL = 4
) (
    input  logic [2**NSEL-1:0] table_bits,
    input  logic [NSEL-1:0]    idx,
    output logic               out
);
    // Table lookup.
    assign out = table_bits[idx];
endmodule

// File: rtl/tcl_level_core.sv
// Module: top of one decision level. It evaluates every class, merges the
// results into clusters, forms the interaction signals and registers all of them.
// Assumes: configuration is static while rst_n is high; synchronous active-low reset.
module tcl_level_core
    import tcl_pkg::*;
#(
    parameter int NCLASS = TCL_NCLASS,
    parameter int NIN    = TCL_NIN,
    parameter int NPF    = TCL_NPF,
    parameter int NCLUS  = TCL_NCLUS,
    parameter int NINV   = TCL_NINV,
    parameter int NINT   = TCL_NINT,
    parameter int LUTSEL = TCL_LUTSEL,
    localparam int BSW   = $clog2(NCLUS + 1),
    localparam int LUTW  = 2 ** LUTSEL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NIN-1:0]          trig_in,
    input  logic [NPF-1:0]          pf_ok,
    input  logic [NCLUS-1:0]        clus_busy,
    input  logic [NCLASS*NIN-1:0]   cfg_in_sel,
    input  logic [NINV*NIN-1:0]     cfg_in_inv,
    input  logic [NCLASS*NPF-1:0]   cfg_pf_sel,
    input  logic [NCLASS*BSW-1:0]   cfg_busy_sel,
    input  logic [NCLASS*NCLUS-1:0] cfg_clus_map,
    input  logic [NINT*LUTW-1:0]    cfg_int_lut,
    output logic [NCLASS-1:0]       class_fire,
    output logic [NCLUS-1:0]        clus_trig,
    output logic [NINT-1:0]         int_sig
);
    logic [NCLASS-1:0] fire_d;
    logic [NCLUS-1:0]  clus_d;
    logic [NINT-1:0]   int_d;

    for (genvar k = 0; k < NCLASS; k++) begin : g_class
        logic [NIN-1:0] inv_k;
        if (k < NINV) begin : g_inv
            assign inv_k = cfg_in_inv[k*NIN +: NIN];
        end else begin : g_noinv
            assign inv_k = '0;
        end
        tcl_class_eval #(.NIN(NIN), .NPF(NPF), .NCLUS(NCLUS), .BSW(BSW)) u_cls (
            .trig     (trig_in),
            .sel      (cfg_in_sel[k*NIN +: NIN]),
            .inv      (inv_k),
            .pf       (pf_ok),
            .pf_sel   (cfg_pf_sel[k*NPF +: NPF]),
            .busy     (clus_busy),
            .busy_idx (cfg_busy_sel[k*BSW +: BSW]),
            .fire     (fire_d[k])
        );
    end

    tcl_cluster_or #(.NCLASS(NCLASS), .NCLUS(NCLUS)) u_or (
        .fire (fire_d),
        .map  (cfg_clus_map),
        .clus (clus_d)
    );

    for (genvar i = 0; i < NINT; i++) begin : g_int
        tcl_int_lut #(.NSEL(LUTSEL)) u_lut (
            .table_bits (cfg_int_lut[i*LUTW +: LUTW]),
            .idx        (trig_in[LUTSEL-1:0]),
            .out        (int_d[i])
        );
    end

    // Output register stage, one bunch crossing of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_fire <= '0;
            clus_trig  <= '0;
            int_sig    <= '0;
        end else begin
            class_fire <= fire_d;
            clus_trig  <= clus_d;
            int_sig    <= int_d;
        end
    end
endmodule

// File: rtl/tcl_level_chk.sv
// Module: property checker for tcl_level_core, attached by bind.
// Assumes: configuration ports are static while rst_n is high.
module tcl_level_chk
    import tcl_pkg::*;
#(
    parameter int NCLASS = TCL_NCLASS,
    parameter int NIN    = TCL_NIN,
    parameter int NPF    = TCL_NPF,
    parameter int NCLUS  = TCL_NCLUS,
    parameter int NINV   = TCL_NINV,
    parameter int NINT   = TCL_NINT,
    parameter int LUTSEL = TCL_LUTSEL,
    localparam int BSW   = $clog2(NCLUS + 1),
    localparam int LUTW  = 2 ** LUTSEL
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NIN-1:0]          trig_in,
    input logic [NPF-1:0]          pf_ok,
    input logic [NCLUS-1:0]        clus_busy,
    input logic [NCLASS*NIN-1:0]   cfg_in_sel,
    input logic [NINV*NIN-1:0]     cfg_in_inv,
    input logic [NCLASS*NPF-1:0]   cfg_pf_sel,
    input logic [NCLASS*BSW-1:0]   cfg_busy_sel,
    input logic [NCLASS*NCLUS-1:0] cfg_clus_map,
    input logic [NINT*LUTW-1:0]    cfg_int_lut,
    input logic [NCLASS-1:0]       class_fire,
    input logic [NCLUS-1:0]        clus_trig,
    input logic [NINT-1:0]         int_sig
);
    logic [2**BSW-1:0] busy_x;
    assign busy_x = {{(2**BSW-NCLUS){1'b0}}, clus_busy};

    for (genvar k = 0; k < NCLASS; k++) begin : g_k
        logic [NIN-1:0] inv_k;
        if (k < NINV) begin : g_i
            assign inv_k = cfg_in_inv[k*NIN +: NIN];
        end else begin : g_n
            assign inv_k = '0;
        end

        // R1 R3
        class_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            class_fire[k] |-> ((($past(trig_in) ^ inv_k) & cfg_in_sel[k*NIN +: NIN])
                               == cfg_in_sel[k*NIN +: NIN]));
        // R2
        empty_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_in_sel[k*NIN +: NIN] == '0) |-> !class_fire[k]);
        // R4
        protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
            class_fire[k] |-> (($past(pf_ok) & cfg_pf_sel[k*NPF +: NPF])
                               == cfg_pf_sel[k*NPF +: NPF]));
        // R5
        busy_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
            class_fire[k] |-> !$past(busy_x[cfg_busy_sel[k*BSW +: BSW]]));
    end

    for (genvar c = 0; c < NCLUS; c++) begin : g_c
        logic [NCLASS-1:0] col;
        always_comb begin
            for (int k = 0; k < NCLASS; k++) col[k] = cfg_clus_map[k*NCLUS + c];
        end
        // R6
        cluster_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clus_trig[c] == |(class_fire & col));
    end

    for (genvar i = 0; i < NINT; i++) begin : g_i
        // R7 R8
        interaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> int_sig[i] == $past(cfg_int_lut[i*LUTW + trig_in[LUTSEL-1:0]]));
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (class_fire == '0 && clus_trig == '0 && int_sig == '0));
endmodule

bind tcl_level_core tcl_level_chk #(
    .NCLASS(NCLASS), .NIN(NIN), .NPF(NPF), .NCLUS(NCLUS),
    .NINV(NINV), .NINT(NINT), .LUTSEL(LUTSEL)
) u_chk (.*);

// File: tb/sim_tcl_level_core.sv
// Bench: table-driven checks, then directed reset and latency tests.
module sim_tcl_level_core;
    localparam int NCLASS = 50, NIN = 24, NPF = 4, NCLUS = 6, NINV = 6, NINT = 2, BSW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NIN-1:0]          trig_in = '0;
    logic [NPF-1:0]          pf_ok = '0;
    logic [NCLUS-1:0]        clus_busy = '0;
    logic [NCLASS*NIN-1:0]   cfg_in_sel = '0;
    logic [NINV*NIN-1:0]     cfg_in_inv = '0;
    logic [NCLASS*NPF-1:0]   cfg_pf_sel = '0;
    logic [NCLASS*BSW-1:0]   cfg_busy_sel = '1;
    logic [NCLASS*NCLUS-1:0] cfg_clus_map = '0;
    logic [NINT*16-1:0]      cfg_int_lut = '0;
    logic [NCLASS-1:0]       class_fire;
    logic [NCLUS-1:0]        clus_trig;
    logic [NINT-1:0]         int_sig;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    tcl_level_core u0 (.*);

    typedef struct packed {
        logic [23:0] tin;
        logic [3:0]  pf;
        logic [5:0]  bz;
        logic [3:0]  cls;   // {class49, class10, class1, class0}
        logic [5:0]  cl;
        logic [1:0]  it;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{24'h000000, 4'b0000, 6'b000000, 4'b0000, 6'b000000, 2'b00},
        '{24'h000010, 4'b0000, 6'b000000, 4'b0001, 6'b000001, 2'b00},
        '{24'h000030, 4'b0001, 6'b000000, 4'b0010, 6'b000110, 2'b00},
        '{24'h000010, 4'b0001, 6'b000010, 4'b0001, 6'b000001, 2'b00},
        '{24'h0000C0, 4'b1100, 6'b000000, 4'b0100, 6'b000100, 2'b00},
        '{24'h0000C0, 4'b0100, 6'b000000, 4'b0000, 6'b000000, 2'b00},
        '{24'h0000C0, 4'b1100, 6'b000001, 4'b0000, 6'b000000, 2'b00},
        '{24'h80001F, 4'b0001, 6'b000000, 4'b1011, 6'b100111, 2'b01},
        '{24'h800007, 4'b0000, 6'b100000, 4'b0000, 6'b000000, 2'b10},
        '{24'h800001, 4'b0000, 6'b000000, 4'b1000, 6'b100000, 2'b10},
        '{24'h0000D0, 4'b1101, 6'b000000, 4'b0111, 6'b000111, 2'b00}
    };

    localparam logic [NCLASS-1:0] WATCHED =
        (50'd1 << 0) | (50'd1 << 1) | (50'd1 << 10) | (50'd1 << 49);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // class0: input 4 high, input 5 low (inverted), no busy veto, cluster 0
        cfg_in_sel[0*NIN + 4] = 1'b1;
        cfg_in_sel[0*NIN + 5] = 1'b1;
        cfg_in_inv[0*NIN + 5] = 1'b1;
        cfg_clus_map[0*NCLUS + 0] = 1'b1;
        // class1: input 4, protection 0, busy of cluster 1, clusters 1 and 2
        cfg_in_sel[1*NIN + 4] = 1'b1;
        cfg_pf_sel[1*NPF + 0] = 1'b1;
        cfg_busy_sel[1*BSW +: BSW] = 3'd1;
        cfg_clus_map[1*NCLUS + 1] = 1'b1;
        cfg_clus_map[1*NCLUS + 2] = 1'b1;
        // class2: empty select, mapped to cluster 3
        cfg_clus_map[2*NCLUS + 3] = 1'b1;
        // class10: inputs 6,7, protection 2,3, busy of cluster 0, cluster 2
        cfg_in_sel[10*NIN + 6] = 1'b1;
        cfg_in_sel[10*NIN + 7] = 1'b1;
        cfg_pf_sel[10*NPF + 2] = 1'b1;
        cfg_pf_sel[10*NPF + 3] = 1'b1;
        cfg_busy_sel[10*BSW +: BSW] = 3'd0;
        cfg_clus_map[10*NCLUS + 2] = 1'b1;
        // class49: input 23, busy of cluster 5, cluster 5
        cfg_in_sel[49*NIN + 23] = 1'b1;
        cfg_busy_sel[49*BSW +: BSW] = 3'd5;
        cfg_clus_map[49*NCLUS + 5] = 1'b1;
        // interaction 0 = AND of four inputs, interaction 1 = parity
        cfg_int_lut = {16'h6996, 16'h8000};

        // R9: firing inputs held during reset give zero outputs
        trig_in = 24'h80001F;
        pf_ok = 4'b0001;
        repeat (3) @(negedge clk);
        chk("R9 reset classes", 64'(class_fire), 64'd0);
        chk("R9 reset clusters", 64'(clus_trig), 64'd0);
        chk("R9 reset interaction", 64'(int_sig), 64'd0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        foreach (VEC[v]) begin
            @(negedge clk);
            trig_in = VEC[v].tin;
            pf_ok = VEC[v].pf;
            clus_busy = VEC[v].bz;
            @(negedge clk);
            chk($sformatf("R1 R3 R4 R5 classes v%0d", v),
                64'({class_fire[49], class_fire[10], class_fire[1], class_fire[0]}),
                64'(VEC[v].cls));
            chk($sformatf("R2 idle classes v%0d", v), 64'(class_fire & ~WATCHED), 64'd0);
            chk($sformatf("R6 clusters v%0d", v), 64'(clus_trig), 64'(VEC[v].cl));
            chk($sformatf("R7 interaction v%0d", v), 64'(int_sig), 64'(VEC[v].it));
        end

        // R8: new inputs appear only after the next rising edge
        @(negedge clk);
        trig_in = 24'h000000;
        pf_ok = 4'b0000;
        clus_busy = '0;
        @(negedge clk);
        trig_in = 24'h80001F;
        pf_ok = 4'b0001;
        #2;
        chk("R8 before edge", 64'(clus_trig), 64'd0);
        @(negedge clk);
        chk("R8 after edge", 64'(clus_trig), 64'h27);

        // R9: reset in mid-run clears on the next edge
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-run reset classes", 64'(class_fire), 64'd0);
        chk("R9 mid-run reset interaction", 64'(int_sig), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 inverted input restored", 64'(class_fire[0]), 64'd1);

        finish_run();
    end
endmodule